// File: doc/BRIEF.md
# Pipelined Lowest-Index Priority Encoder

This block turns a multi-match bit vector, one bit per rule, into a single winning rule number. Rules are held in order of falling priority, so bit 0 is the most important rule and the lowest set bit is the one to report. A vector enters on every clock. The block returns the index of the lowest set bit and a hit flag that says whether any bit was set at all.

The reduction is a binary tree cut into log2(VEC_W) register stages. Each stage merges neighbouring pairs of (hit, partial index) entries. The lower-index entry of a pair wins when its hit is set. Otherwise the upper entry wins, and the stage's own index bit is set to 1. Every stage has only one two-way select in front of its registers, so the critical path does not grow with the vector width. The encoder sits straight after a bit-vector lookup pipeline that produces one vector per cycle.

The stream interface has no back-pressure. There is no ready signal on either side. A vector offered with `in_valid` high is always taken, and the consumer must accept every cycle in which `out_valid` is high. `VEC_W` must be a power of two. A rule set with fewer rules is padded with zeros at the high, low-priority end of the vector.

Top module: `prio_enc_pipe`

## Requirements
- R1: When at least one bit of an accepted vector is set, the result has `out_hit` = 1 and `out_idx` equal to the position of the lowest set bit (bit 0 has the highest priority).
- R2: A result appears exactly log2(VEC_W) clock cycles after its vector is sampled with `in_valid` high, with `out_valid` high in that cycle.
- R3: A new vector is accepted on every clock without stalls. Back-to-back vectors give back-to-back results in the same order.
- R4: A vector with no bit set gives `out_hit` = 0 and `out_idx` = 0.
- R5: While `rst_n` is low, `out_valid`, `out_hit` and `out_idx` are all 0. Vectors that were in flight when reset was asserted never appear at the output.
- R6: An all-ones vector reports index 0. A vector with only the top bit set reports index VEC_W-1.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low log2(VEC_W) cycles later, whatever value `in_vec` holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_vec` holds a vector to resolve |
| in_vec | input | VEC_W | Multi-match vector, bit 0 highest priority |
| out_valid | output | 1 | Result of a vector sampled log2(VEC_W) cycles earlier |
| out_hit | output | 1 | At least one bit of that vector was set |
| out_idx | output | log2(VEC_W) | Lowest set bit position, 0 on a miss |

## Verification
The bench builds the encoder with `VEC_W` = 16, which gives four stages. At that width every single-bit position can be swept, and the top-bit corner case reaches the full index width. Four stages also leave room to assert reset while several vectors are in flight at different depths. The same width lets streams with and without gaps show the exact four-cycle latency and that `in_vec` is ignored in invalid cycles. A reference that scans for the lowest set bit checks random vectors of mixed density.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

  // Number of merge levels for a vector of the given width.
  function automatic int ppe_levels(input int width);
    return $clog2(width);
  endfunction

  // True when the width is a power of two of at least two.
  function automatic bit ppe_width_ok(input int width);
    return (width >= 2) && ((width & (width - 1)) == 0);
  endfunction

endpackage

// File: rtl/ppe_merge.sv
// Combinational merge of one pair of tree entries.
module ppe_merge #(
  parameter int IDX_W = 4,
  parameter int BIT   = 0
) (
  input  logic             lo_hit,
  input  logic [IDX_W-1:0] lo_idx,
  input  logic             hi_hit,
  input  logic [IDX_W-1:0] hi_idx,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] hi_marked;

  always_comb begin
    hi_marked      = hi_idx;
    hi_marked[BIT] = 1'b1;
    hit            = lo_hit | hi_hit;
    if (lo_hit)      idx = lo_idx;
    else if (hi_hit) idx = hi_marked;
    else             idx = '0;
  end

endmodule

// File: rtl/ppe_stage.sv
// One registered level of the reduction tree: IN_CNT entries in, IN_CNT/2 out.
module ppe_stage #(
  parameter int IN_CNT = 16,
  parameter int IDX_W  = 4,
  parameter int LEVEL  = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [IN_CNT-1:0]            in_hit,
  input  logic [IN_CNT-1:0][IDX_W-1:0] in_idx,
  output logic                         out_valid,
  output logic [IN_CNT/2-1:0]          out_hit,
  output logic [IN_CNT/2-1:0][IDX_W-1:0] out_idx
);

  localparam int OUT_CNT = IN_CNT / 2;

  logic [OUT_CNT-1:0]            m_hit;
  logic [OUT_CNT-1:0][IDX_W-1:0] m_idx;

  for (genvar j = 0; j < OUT_CNT; j++) begin : g_pair
    ppe_merge #(.IDX_W(IDX_W), .BIT(LEVEL)) u_merge (
      .lo_hit (in_hit[2*j]),
      .lo_idx (in_idx[2*j]),
      .hi_hit (in_hit[2*j+1]),
      .hi_idx (in_idx[2*j+1]),
      .hit    (m_hit[j]),
      .idx    (m_idx[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= '0;
      out_idx   <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= m_hit;
      out_idx   <= m_idx;
    end
  end

  // R2: a valid result at this level came from a valid entry one cycle earlier
  p_valid_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid) |-> $past(in_valid));

  // R7: an accepted vector moves on to the next level
  p_valid_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  for (genvar j = 0; j < OUT_CNT; j++) begin : g_chk
    // R4: an entry without a hit carries a zero index into the next level
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !out_hit[j] |-> (out_idx[j] == '0));
    if (LEVEL + 1 < IDX_W) begin : g_hi
      // R1: index bits above this level have not been decided yet and stay zero
      p_idx_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_idx[j][IDX_W-1:LEVEL+1] == '0);
    end
  end

endmodule

// File: rtl/prio_enc_pipe.sv
module prio_enc_pipe
  import ppe_pkg::*;
#(
  parameter int VEC_W = 16,
  localparam int LVL   = ppe_levels(VEC_W),
  localparam int IDX_W = LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_vec,
  output logic             out_valid,
  output logic             out_hit,
  output logic [IDX_W-1:0] out_idx
);

  initial begin
    p_width_ok_r1: assert (ppe_width_ok(VEC_W));
  end

  for (genvar s = 0; s <= LVL; s++) begin : g_lvl
    localparam int CNT = VEC_W >> s;
    logic                 vld;
    logic [CNT-1:0]       hit;
    logic [CNT-1:0][IDX_W-1:0] idx;

    if (s == 0) begin : g_in
      assign vld = in_valid;
      assign hit = in_vec;
      assign idx = '0;
    end else begin : g_st
      ppe_stage #(
        .IN_CNT (VEC_W >> (s - 1)),
        .IDX_W  (IDX_W),
        .LEVEL  (s - 1)
      ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (g_lvl[s-1].vld),
        .in_hit    (g_lvl[s-1].hit),
        .in_idx    (g_lvl[s-1].idx),
        .out_valid (vld),
        .out_hit   (hit),
        .out_idx   (idx)
      );
    end
  end

  assign out_valid = g_lvl[LVL].vld;
  assign out_hit   = g_lvl[LVL].hit[0];
  assign out_idx   = g_lvl[LVL].idx[0];

  // R4: a valid miss reports index zero at the block's edge
  p_out_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0));

endmodule

// File: tb/prio_enc_pipe_tb.sv
module prio_enc_pipe_tb;

  localparam int VW  = 16;
  localparam int LVL = 4;
  localparam int IW  = 4;
  localparam int NT  = 12;

  // {expected hit, expected index, vector}
  localparam logic [20:0] TBL [NT] = '{
    {1'b1, 4'd0,  16'h0001},
    {1'b1, 4'd15, 16'h8000},
    {1'b1, 4'd0,  16'hFFFF},
    {1'b0, 4'd0,  16'h0000},
    {1'b1, 4'd8,  16'h0100},
    {1'b1, 4'd4,  16'hF0F0},
    {1'b1, 4'd0,  16'h8001},
    {1'b1, 4'd1,  16'h0006},
    {1'b1, 4'd10, 16'h4400},
    {1'b1, 4'd1,  16'h7FFE},
    {1'b0, 4'd0,  16'h0000},
    {1'b1, 4'd11, 16'h0800}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_vec = '0;
  logic          out_valid;
  logic          out_hit;
  logic [IW-1:0] out_idx;

  int n_chk = 0;
  int n_bad = 0;

  logic [VW-1:0] s_vec [64];
  logic          s_vld [64];
  logic          s_hit [64];
  logic [IW-1:0] s_idx [64];
  int            s_n;

  always #4 clk = ~clk;

  prio_enc_pipe #(.VEC_W(VW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_idx   (out_idx)
  );

  function automatic void ref_enc(input logic [VW-1:0] v, output logic h, output logic [IW-1:0] ix);
    h  = 1'b0;
    ix = '0;
    for (int b = VW - 1; b >= 0; b--) begin
      if (v[b]) begin
        h  = 1'b1;
        ix = IW'(b);
      end
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Stream s_* entries back to back; results are checked LVL cycles later.
  task automatic play(input string tag);
    for (int i = 0; i < s_n + LVL; i++) begin
      @(negedge clk);
      if (i >= LVL) begin
        check({tag, " valid"}, 32'(out_valid), 32'(s_vld[i-LVL]));
        if (s_vld[i-LVL]) begin
          check({tag, " hit"}, 32'(out_hit), 32'(s_hit[i-LVL]));
          check({tag, " idx"}, 32'(out_idx), 32'(s_idx[i-LVL]));
        end
      end
      if (i < s_n) begin
        in_valid = s_vld[i];
        in_vec   = s_vec[i];
      end else begin
        in_valid = 1'b0;
        in_vec   = '0;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R5: reset state
    repeat (2) @(negedge clk);
    check("R5 reset valid", 32'(out_valid), 32'd0);
    check("R5 reset hit", 32'(out_hit), 32'd0);
    check("R5 reset idx", 32'(out_idx), 32'd0);
    rst_n = 1'b1;

    // R1 R3 R4 R6: table walked back to back
    s_n = NT;
    for (int i = 0; i < NT; i++) begin
      s_vec[i] = TBL[i][15:0];
      s_idx[i] = TBL[i][19:16];
      s_hit[i] = TBL[i][20];
      s_vld[i] = 1'b1;
    end
    play("R1 R3 R6 table");

    // R1: random vectors of mixed density against the scan reference
    s_n = 48;
    for (int i = 0; i < 48; i++) begin
      case (i % 3)
        0:       s_vec[i] = VW'($urandom);
        1:       s_vec[i] = VW'($urandom & $urandom & $urandom);
        default: s_vec[i] = VW'($urandom & $urandom & $urandom & $urandom & $urandom);
      endcase
      s_vld[i] = 1'b1;
      ref_enc(s_vec[i], s_hit[i], s_idx[i]);
    end
    play("R1 random");

    // R1 R6: every single-bit position, top bit included
    s_n = VW;
    for (int i = 0; i < VW; i++) begin
      s_vec[i] = VW'(1) << i;
      s_vld[i] = 1'b1;
      s_hit[i] = 1'b1;
      s_idx[i] = IW'(i);
    end
    play("R6 single bit");

    // R7: gaps with junk on in_vec while invalid
    s_n = 20;
    for (int i = 0; i < 20; i++) begin
      s_vec[i] = VW'($urandom) | VW'(1);
      s_vld[i] = (i % 3) != 1;
      if (!s_vld[i]) s_vec[i] = 16'hFFFF;
      else s_vec[i] = s_vec[i] << (i % VW);
      ref_enc(s_vec[i], s_hit[i], s_idx[i]);
    end
    play("R7 gaps");

    // R2: one vector alone, out_valid only in cycle LVL
    @(negedge clk);
    in_valid = 1'b1;
    in_vec   = 16'h0040;
    @(negedge clk);
    in_valid = 1'b0;
    in_vec   = '0;
    for (int c = 1; c < LVL; c++) begin
      check("R2 early valid", 32'(out_valid), 32'd0);
      @(negedge clk);
    end
    check("R2 latency valid", 32'(out_valid), 32'd1);
    check("R2 latency idx", 32'(out_idx), 32'd6);
    @(negedge clk);
    check("R2 single pulse", 32'(out_valid), 32'd0);

    // R4: all-zero alone
    in_valid = 1'b1;
    in_vec   = '0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LVL - 1) @(negedge clk);
    check("R4 zero valid", 32'(out_valid), 32'd1);
    check("R4 zero hit", 32'(out_hit), 32'd0);
    check("R4 zero idx", 32'(out_idx), 32'd0);

    // R5: reset with vectors in flight
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_vec   = 16'h0200;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_vec   = '0;
    rst_n    = 1'b0;
    #1;
    check("R5 async valid", 32'(out_valid), 32'd0);
    check("R5 async hit", 32'(out_hit), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c <= LVL; c++) begin
      @(negedge clk);
      check("R5 flushed", 32'(out_valid), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule